// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises bytes onto a single line in start/data/parity/stop frames. Software writes a byte into a holding register and then clears the "data empty" flag to mark the byte as ready. As soon as the internal shift register is free, the hardware copies the byte across and sets the flag again. While that copy shifts out, software can already load the next byte. Because of this two-stage buffering, frames leave the pin one after another with no idle gap.

Timing comes from an external baud tick, and every bit lasts a fixed number of ticks. Configuration inputs set four things for each frame:
- a shortened data length of one bit less,
- most-significant-bit-first order,
- whether a parity bit is added,
- whether that parity is odd or even.

The block keeps two status flags, and each one also serves as an interrupt request:
- **Data empty** means the holding register may be written.
- **Transmit end** means the last frame has finished and nothing is waiting to be sent.

Software can only clear these flags, never set them. It clears a flag by writing 0 to its field through the status write port.

Top module: `async_tx_dbuf`

## Requirements
- R1: Out of reset the line is 1, and the data-empty and transmit-end flags both read 1.
- R2: Each frame drives, in order: a start bit of 0, the data bits, the parity bit if enabled, and a stop bit of 1. Every bit lasts 16 baud ticks.
- R3: With the full 8-bit length and msb-first set, data bit 7 is sent first. With msb-first clear, bit 0 is sent first.
- R4: With the short length selected, 7 data bits (bits 6..0) are sent LSB first whatever msb-first says. Bit 7 is not sent.
- R5: With parity enabled, one extra bit follows the data. That bit is the XOR of the sent data bits when the odd select is 0, and its inverse when the odd select is 1.
- R6: When data-empty is 0 (or is being cleared this clock), the enable is high and the shifter is idle, the byte is copied into the shifter in that clock. Data-empty then reads 1 and the start bit appears on the following clock.
- R7: If data-empty is cleared before the current stop bit ends, the next start bit begins on the clock right after the 16th stop-bit tick. No idle time is inserted.
- R8: A status write with a field at 0 clears that flag. A field at 1 leaves the flag unchanged, so software can never set data-empty or transmit-end.
- R9: Transmit-end rises when a stop bit ends with no byte pending, and the line then stays at 1. Transmit-end falls when a byte is copied into the shifter.
- R10: While the enable is low, the line is 1 from the next clock, the shifter is idle and no byte is copied.
- R11: A data-empty clear issued in the same clock as the end of a stop bit starts the next frame immediately. Transmit-end stays 0.
- R12: Length, order and parity settings are captured when a byte is copied. A change afterwards does not alter a frame already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-clock pulse, 16 per bit |
| cfg_len7 | input | 1 | 1 selects the short (7-bit) data length |
| cfg_msb_first | input | 1 | 1 selects MSB-first order (8-bit length only) |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| wr_data_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte written to the holding register |
| wr_stat_en | input | 1 | Write strobe for the status flags |
| wr_stat_tde | input | 1 | Data-empty field; 0 clears the flag |
| wr_stat_tend | input | 1 | Transmit-end field; 0 clears the flag |
| txd | output | 1 | Serial line |
| tde_irq | output | 1 | Data-empty flag and interrupt request |
| tend_irq | output | 1 | Transmit-end flag and interrupt request |

## Verification
The delicate coincidence is the end of a stop bit and a software clear of data-empty landing in the same clock. The end of the stop bit alone would raise transmit-end and park the line. The clear alone would only mark a byte as pending. To provoke it, the bench counts baud ticks from the copy of a 10-bit frame and issues the clear exactly on the 160th tick. The bench judges the result one clock later: data-empty must be 1, transmit-end must still be 0, and the line must already carry the next start bit. A serial decoder then confirms that the next frame followed without a gap.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic len_short;
        logic msb_first;
        logic par_en;
        logic par_odd;
    } tx_cfg_t;

endpackage

// File: rtl/tx_holdreg.sv
module tx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_stat_en,
    input  logic              wr_stat_tde,
    input  logic              wr_stat_tend,
    input  logic              take,
    input  logic              stop_end,
    output logic              avail,
    output logic [DATA_W-1:0] avail_data,
    output logic              tde,
    output logic              tend
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              tde;
        logic              tend;
    } hold_regs_t;

    hold_regs_t h_d, h_q;
    logic       clr_tde, clr_tend;

    always_comb begin
        clr_tde    = wr_stat_en & ~wr_stat_tde;
        clr_tend   = wr_stat_en & ~wr_stat_tend;
        // a clear in this clock is forwarded so a free shifter can take at once
        avail      = ~h_q.tde | clr_tde;
        avail_data = wr_data_en ? wr_data : h_q.hold;

        h_d = h_q;
        if (wr_data_en) h_d.hold = wr_data;
        if (clr_tde)    h_d.tde  = 1'b0;
        if (take)       h_d.tde  = 1'b1;
        if (clr_tend)   h_d.tend = 1'b0;
        if (stop_end && !take) h_d.tend = 1'b1;
        if (take)       h_d.tend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.hold <= '0;
            h_q.tde  <= 1'b1;
            h_q.tend <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    assign tde  = h_q.tde;
    assign tend = h_q.tend;

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import async_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  tx_cfg_t           cfg,
    input  logic              avail,
    input  logic [DATA_W-1:0] avail_data,
    output logic              take,
    output logic              stop_end,
    output logic              txd
);

    localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] LEN_FULL  = BIT_W'(DATA_W);
    localparam logic [BIT_W-1:0] LEN_SHORT = BIT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] SHORT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  left;
        logic [DATA_W-1:0] sr;
        logic              par;
        logic              msb;
        logic              par_en;
    } sh_regs_t;

    sh_regs_t          s_d, s_q;
    logic              tick_last;
    logic [DATA_W-1:0] load_data;

    always_comb begin
        s_d       = s_q;
        take      = 1'b0;
        stop_end  = 1'b0;
        tick_last = baud_tick && (s_q.cnt == CNT_LAST);
        load_data = cfg.len_short ? (avail_data & SHORT_MASK) : avail_data;

        if (!tx_en) begin
            s_d.state = ST_IDLE;
            s_d.cnt   = '0;
        end else begin
            if (s_q.state != ST_IDLE && baud_tick) s_d.cnt = s_q.cnt + 1'b1;
            case (s_q.state)
                ST_IDLE: begin
                    if (avail) take = 1'b1;
                end
                ST_START: begin
                    if (tick_last) begin
                        s_d.state = ST_DATA;
                        s_d.cnt   = '0;
                    end
                end
                ST_DATA: begin
                    if (tick_last) begin
                        s_d.cnt  = '0;
                        s_d.left = s_q.left - 1'b1;
                        s_d.sr   = s_q.msb ? {s_q.sr[DATA_W-2:0], 1'b0}
                                           : {1'b0, s_q.sr[DATA_W-1:1]};
                        if (s_q.left == BIT_W'(1))
                            s_d.state = s_q.par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    if (tick_last) begin
                        s_d.state = ST_STOP;
                        s_d.cnt   = '0;
                    end
                end
                ST_STOP: begin
                    if (tick_last) begin
                        stop_end = 1'b1;
                        s_d.cnt  = '0;
                        if (avail) take = 1'b1;
                        else       s_d.state = ST_IDLE;
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase

            if (take) begin
                s_d.state  = ST_START;
                s_d.cnt    = '0;
                s_d.sr     = load_data;
                s_d.left   = cfg.len_short ? LEN_SHORT : LEN_FULL;
                s_d.msb    = cfg.msb_first & ~cfg.len_short;
                s_d.par_en = cfg.par_en;
                s_d.par    = (^load_data) ^ cfg.par_odd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state  <= ST_IDLE;
            s_q.cnt    <= '0;
            s_q.left   <= '0;
            s_q.sr     <= '0;
            s_q.par    <= 1'b0;
            s_q.msb    <= 1'b0;
            s_q.par_en <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = s_q.msb ? s_q.sr[DATA_W-1] : s_q.sr[0];
            ST_PAR:   txd = s_q.par;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/async_tx_dbuf.sv
module async_tx_dbuf
    import async_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              cfg_len7,
    input  logic              cfg_msb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_stat_en,
    input  logic              wr_stat_tde,
    input  logic              wr_stat_tend,
    output logic              txd,
    output logic              tde_irq,
    output logic              tend_irq
);

    tx_cfg_t           cfg;
    logic              avail;
    logic [DATA_W-1:0] avail_data;
    logic              take;
    logic              stop_end;

    assign cfg = '{len_short: cfg_len7, msb_first: cfg_msb_first,
                   par_en: cfg_par_en, par_odd: cfg_par_odd};

    tx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_data_en   (wr_data_en),
        .wr_data      (wr_data),
        .wr_stat_en   (wr_stat_en),
        .wr_stat_tde  (wr_stat_tde),
        .wr_stat_tend (wr_stat_tend),
        .take         (take),
        .stop_end     (stop_end),
        .avail        (avail),
        .avail_data   (avail_data),
        .tde          (tde_irq),
        .tend         (tend_irq)
    );

    tx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .baud_tick  (baud_tick),
        .cfg        (cfg),
        .avail      (avail),
        .avail_data (avail_data),
        .take       (take),
        .stop_end   (stop_end),
        .txd        (txd)
    );

endmodule

// File: rtl/async_tx_dbuf_chk.sv
module async_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic txd,
    input logic tde_irq,
    input logic tend_irq,
    input logic take,
    input logic stop_end
);

    // R10
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd);

    // R6
    copy_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (tde_irq && !txd));

    // R8
    no_soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tde_irq |=> (tde_irq == $past(take)));

    // R9
    end_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tend_irq) |-> ($past(stop_end) && tde_irq && txd));

    // R11
    collide_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_end && take) |=> (!tend_irq && !txd));

endmodule

bind async_tx_dbuf async_tx_dbuf_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .txd      (txd),
    .tde_irq  (tde_irq),
    .tend_irq (tend_irq),
    .take     (take),
    .stop_end (stop_end)
);

// File: tb/tb_async_tx_dbuf.sv
`timescale 1ns/1ps
module tb_async_tx_dbuf;

    logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, baud_tick = 1'b0;
    logic cfg_len7 = 1'b0, cfg_msb_first = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic wr_data_en = 1'b0, wr_stat_en = 1'b0, wr_stat_tde = 1'b1, wr_stat_tend = 1'b1;
    logic [7:0] wr_data = 8'h00;
    logic txd, tde_irq, tend_irq;

    int n_chk = 0, n_fail = 0, cyc = 0, last_stop = 0;
    bit mon_on = 1'b0, done = 1'b0;

    logic [11:0] exp_bits_q[$];
    int          exp_n_q[$];
    bit          exp_contig_q[$];
    string       exp_tag_q[$];

    // {len7, msb_first, par_en, par_odd, data}
    localparam logic [11:0] VEC [12] = '{
        {4'b0000, 8'hA5}, {4'b0000, 8'h3C}, {4'b0100, 8'hA5}, {4'b0100, 8'h0F},
        {4'b1100, 8'hE1}, {4'b1100, 8'h5A}, {4'b0010, 8'hB7}, {4'b0010, 8'h96},
        {4'b0011, 8'h96}, {4'b0011, 8'h01}, {4'b1011, 8'h7F}, {4'b1111, 8'h80}
    };

    async_tx_dbuf dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
        .cfg_len7(cfg_len7), .cfg_msb_first(cfg_msb_first),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .wr_data_en(wr_data_en), .wr_data(wr_data),
        .wr_stat_en(wr_stat_en), .wr_stat_tde(wr_stat_tde), .wr_stat_tend(wr_stat_tend),
        .txd(txd), .tde_irq(tde_irq), .tend_irq(tend_irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(posedge clk);
            #1 baud_tick = ~baud_tick;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_frame(input logic [3:0] c, input logic [7:0] d,
                                input bit contig, input string tag);
        logic [11:0] b;
        int k, nd;
        b    = '0;
        nd   = c[3] ? 7 : 8;
        b[0] = 1'b0;
        for (int i = 0; i < nd; i++)
            b[1+i] = (c[2] && !c[3]) ? d[7-i] : d[i];
        k = 1 + nd;
        if (c[1]) begin
            b[k] = (c[3] ? ^d[6:0] : ^d) ^ c[0];
            k++;
        end
        b[k] = 1'b1;
        exp_bits_q.push_back(b);
        exp_n_q.push_back(k + 1);
        exp_contig_q.push_back(contig);
        exp_tag_q.push_back(tag);
    endtask

    task automatic wait_tde();
        int k = 0;
        while (tde_irq !== 1'b1 && k < 5000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_tend();
        int k = 0;
        while (tend_irq !== 1'b1 && k < 5000) begin @(negedge clk); k++; end
    endtask

    // serial decoder: mid-bit sampling, 32 clocks per bit
    initial begin
        logic [11:0] e, got;
        int n;
        bit ctg;
        string tag;
        forever begin
            @(negedge clk);
            if (mon_on && txd === 1'b0) begin
                if (exp_n_q.size() == 0) begin
                    chk("R2", 32'd1, 32'd0, "unexpected start bit");
                    repeat (32) @(negedge clk);
                end else begin
                    e   = exp_bits_q.pop_front();
                    n   = exp_n_q.pop_front();
                    ctg = exp_contig_q.pop_front();
                    tag = exp_tag_q.pop_front();
                    if (ctg) chk("R7", 32'(cyc - last_stop <= 17), 32'd1, "gap before start");
                    got = '0;
                    repeat (16) @(negedge clk);
                    got[0] = txd;
                    for (int i = 1; i < n; i++) begin
                        repeat (32) @(negedge clk);
                        got[i] = txd;
                    end
                    last_stop = cyc;
                    chk(tag, 32'(got), 32'(e), "frame bits");
                end
            end
        end
    end

    initial begin
        int cnt;
        logic [3:0] prev_c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", txd, 1'b1, "line after reset");
        chk("R1", tde_irq, 1'b1, "data-empty after reset");
        chk("R1", tend_irq, 1'b1, "end flag after reset");

        // R10: disabled, a pending byte must not be copied
        wr_data_en = 1'b1; wr_data = 8'hC3;
        wr_stat_en = 1'b1; wr_stat_tde = 1'b0; wr_stat_tend = 1'b1;
        @(negedge clk);
        wr_data_en = 1'b0; wr_stat_en = 1'b0; wr_stat_tde = 1'b1;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (txd !== 1'b1) cnt++;
            @(negedge clk);
        end
        chk("R10", 32'(cnt), 32'd0, "line not idle while disabled");
        chk("R10", tde_irq, 1'b0, "copy while disabled");
        expect_frame(4'b0000, 8'hC3, 1'b0, "R6");
        mon_on = 1'b1;
        tx_en = 1'b1;
        @(negedge clk);
        chk("R6", tde_irq, 1'b1, "data-empty after copy");
        chk("R6", txd, 1'b0, "start bit after copy");
        chk("R9", tend_irq, 1'b0, "end flag after copy");

        // vector table: back-to-back stream with changing format
        prev_c = 4'b0000;
        for (int i = 0; i < 12; i++) begin
            wait_tde();
            if (i > 0) chk("R9", tend_irq, 1'b0, "end flag mid stream");
            {cfg_len7, cfg_msb_first, cfg_par_en, cfg_par_odd} = VEC[i][11:8];
            wr_data_en = 1'b1; wr_data = VEC[i][7:0];
            wr_stat_en = 1'b1; wr_stat_tde = 1'b0;
            if (VEC[i][11:8] != prev_c)  expect_frame(VEC[i][11:8], VEC[i][7:0], 1'b1, "R12");
            else if (VEC[i][11])         expect_frame(VEC[i][11:8], VEC[i][7:0], 1'b1, "R4");
            else if (VEC[i][9])          expect_frame(VEC[i][11:8], VEC[i][7:0], 1'b1, "R5");
            else if (VEC[i][10])         expect_frame(VEC[i][11:8], VEC[i][7:0], 1'b1, "R3");
            else                         expect_frame(VEC[i][11:8], VEC[i][7:0], 1'b1, "R2");
            prev_c = VEC[i][11:8];
            @(negedge clk);
            wr_data_en = 1'b0; wr_stat_en = 1'b0; wr_stat_tde = 1'b1;
        end
        wait_tend();
        chk("R9", tend_irq, 1'b1, "end flag after stream");
        chk("R9", txd, 1'b1, "line idle after stream");
        chk("R2", 32'(exp_n_q.size()), 32'd0, "frames not seen");

        // R8: clear-only status writes
        {cfg_len7, cfg_msb_first, cfg_par_en, cfg_par_odd} = 4'b0000;
        wr_stat_en = 1'b1; wr_stat_tde = 1'b1; wr_stat_tend = 1'b0;
        @(negedge clk);
        wr_stat_en = 1'b0; wr_stat_tend = 1'b1;
        chk("R8", tend_irq, 1'b0, "end flag clear by 0");
        chk("R8", tde_irq, 1'b1, "data-empty kept by 1");
        chk("R8", txd, 1'b1, "no frame from a write of 1");
        wr_data_en = 1'b1; wr_data = 8'h11; wr_stat_en = 1'b1; wr_stat_tde = 1'b0;
        expect_frame(4'b0000, 8'h11, 1'b0, "R2");
        @(negedge clk);
        wr_data = 8'h22;
        expect_frame(4'b0000, 8'h22, 1'b1, "R2");
        @(negedge clk);
        wr_data_en = 1'b0; wr_stat_en = 1'b0; wr_stat_tde = 1'b1;
        chk("R8", tde_irq, 1'b0, "data-empty cleared while busy");
        wr_stat_en = 1'b1; wr_stat_tde = 1'b1; wr_stat_tend = 1'b1;
        @(negedge clk);
        wr_stat_en = 1'b0;
        chk("R8", tde_irq, 1'b0, "data-empty set by software");
        chk("R8", tend_irq, 1'b0, "end flag set by software");
        wait_tend();

        // R11: clear lands on the last stop-bit tick
        repeat (5) @(negedge clk);
        wr_data_en = 1'b1; wr_data = 8'h5E; wr_stat_en = 1'b1; wr_stat_tde = 1'b0;
        expect_frame(4'b0000, 8'h5E, 1'b0, "R2");
        @(negedge clk);
        wr_stat_en = 1'b0; wr_stat_tde = 1'b1;
        chk("R6", tde_irq, 1'b1, "copy in clear clock");
        wr_data = 8'h9D;
        cnt = 0;
        forever begin
            if (baud_tick) cnt++;
            if (cnt == 160) break;
            @(negedge clk);
            wr_data_en = 1'b0;
        end
        wr_stat_en = 1'b1; wr_stat_tde = 1'b0;
        expect_frame(4'b0000, 8'h9D, 1'b1, "R11");
        @(negedge clk);
        wr_stat_en = 1'b0; wr_stat_tde = 1'b1;
        chk("R11", tde_irq, 1'b1, "data-empty after collision");
        chk("R11", tend_irq, 1'b0, "end flag after collision");
        chk("R11", txd, 1'b0, "start bit after collision");
        wait_tend();
        chk("R2", 32'(exp_n_q.size()), 32'd0, "frames not seen");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule